// File: doc/BRIEF.md
# Ethernet Receive Station Address Filter

This block sits on the receive side of a 10G Ethernet MAC, between the MAC's 64-bit beat stream and the downstream packet buffering. The MAC stream cannot be stalled: once a frame starts, one beat may arrive on every clock until the last. Each beat is written into a local FIFO as it arrives. The destination address in the first six bytes of the frame is compared with a programmed station address, and the all-ones broadcast address also passes. When promiscuous mode is on, every frame passes the address test.

On the last beat, the block combines the address result with the good/bad status that the MAC gives on that beat. A frame that is accepted becomes visible to the output all at once. A frame that is rejected disappears: the write pointer returns to the last committed position. A frame that runs into a full FIFO is dropped in the same way, and its remaining beats are ignored. The event also sets a sticky overflow flag.

Committed beats leave the block one per clock, in arrival order, with no handshake. A small register port holds the station address, the promiscuous enable and the overflow flag.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, register 0 reads 0x00000000, register 1 (station address low word) reads 0xAABBCCDD, register 2 (station address high half in bits 15:0) reads 0x0000EEFF, and outValid is 0.
- R2: The 48-bit station address is {reg2[15:0], reg1}. A good frame whose destination matches it is passed unchanged, every beat keeping its data, byte enables and last flag. Address bits 47:40 are the first byte on the wire, carried in inData[7:0] of the first beat, and bits 7:0 are the sixth byte, in inData[47:40].
- R3: A frame whose destination is neither the station address nor broadcast, received with promiscuous mode off, produces no output beats.
- R4: A frame that ends with inGood low produces no output beats, whatever its address and whatever the mode.
- R5: A good frame with destination FF:FF:FF:FF:FF:FF passes even with promiscuous mode off.
- R6: When bit 0 of register 0 is 1 (promiscuous mode), every good frame passes, whatever its destination.
- R7: A frame that arrives while the FIFO holds DEPTH entries produces no output beats. Every later beat of that frame is discarded, and bit 31 of register 0 is set.
- R8: Bit 31 of register 0 stays set until reset, and frames received after an overflow are still filtered normally. Writes to register 0 change only bit 0.
- R9: The first beat of an accepted frame appears on the output in the cycle right after the clock edge that takes in its last beat. Accepted frames leave back to back, one beat per cycle, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Receive beat valid |
| inData | input | 64 | Receive beat data, first wire byte in bits 7:0 |
| inKeep | input | 8 | Byte enables of the beat |
| inLast | input | 1 | Last beat of the frame |
| inGood | input | 1 | Frame status from the MAC, sampled with inLast |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| outValid | output | 1 | Committed beat valid |
| outData | output | 64 | Committed beat data |
| outKeep | output | 8 | Committed beat byte enables |
| outLast | output | 1 | Last beat of a committed frame |

## Verification
The bench drives a frame longer than the FIFO. A design that kept the first part of that frame would release a truncated frame, and one that went on writing after the FIFO filled would send out corrupted beats. It also sends a dropped frame followed at once by an accepted one. If the rewind reached the wrong position, beats of the rejected frame would leak out ahead of the good frame. Single-beat frames check that the address is taken from the current beat and not from a stale register. A byte-reversed address compare would pass the reset station address the wrong way round and reject frames that should pass.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
  // Strobes from the frame controller to the FIFO datapath
  typedef struct packed {
    logic wrEn;    // store the current beat
    logic commit;  // make the frame up to and including this beat visible
    logic rewind;  // discard everything written since the last commit
  } fifoStrobe_t;
endpackage

// File: rtl/eth_filt_fifo.sv
module eth_filt_fifo
  import eth_filt_pkg::*;
#(
  parameter int DW    = 64,
  parameter int KW    = DW / 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   str,
  input  logic [DW-1:0] inData,
  input  logic [KW-1:0] inKeep,
  input  logic          inLast,
  output logic          full,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic [KW-1:0] outKeep,
  output logic          outLast
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + KW + 1;
  localparam logic [AW:0] DEPTH_P = (AW + 1)'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wrPtr, commitPtr, rdPtr;
  logic [EW-1:0] rdEntry;

  assign full     = (wrPtr - rdPtr) == DEPTH_P;
  assign outValid = rdPtr != commitPtr;
  assign rdEntry  = mem[rdPtr[AW-1:0]];
  assign {outLast, outKeep, outData} = rdEntry;

  always_ff @(posedge clk) begin
    if (str.wrEn) mem[wrPtr[AW-1:0]] <= {inLast, inKeep, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
    end else begin
      if (str.rewind)    wrPtr <= commitPtr;
      else if (str.wrEn) wrPtr <= wrPtr + 1'b1;
      if (str.commit)    commitPtr <= wrPtr + 1'b1;
      if (outValid)      rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/eth_filt_ctrl.sv
module eth_filt_ctrl
  import eth_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [47:0] hdr,
  input  logic        inLast,
  input  logic        inGood,
  input  logic        full,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output fifoStrobe_t str,
  output logic        ovfFlag
);
  logic        inFrame, matchReg, dropping, promisc;
  logic [31:0] staLo;
  logic [15:0] staHi;
  logic [47:0] station, dest;
  logic        matchNow, hit, accept, ovfNow;

  assign station  = {staHi, staLo};
  // first wire byte is the most significant address byte
  assign dest     = {hdr[7:0], hdr[15:8], hdr[23:16], hdr[31:24], hdr[39:32], hdr[47:40]};
  assign matchNow = (dest == station) || (&dest);
  assign hit      = promisc || (inFrame ? matchReg : matchNow);
  assign accept   = inValid && !dropping && !full;
  assign ovfNow   = inValid && !dropping && full;

  always_comb begin
    str.wrEn   = accept;
    str.commit = accept && inLast && inGood && hit;
    str.rewind = ovfNow || (accept && inLast && !(inGood && hit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      matchReg <= 1'b0;
      dropping <= 1'b0;
      promisc  <= 1'b0;
      ovfFlag  <= 1'b0;
      staLo    <= 32'hAABB_CCDD;
      staHi    <= 16'hEEFF;
    end else begin
      if (inValid) begin
        inFrame  <= !inLast;
        if (!inFrame) matchReg <= matchNow;
        dropping <= (dropping || full) && !inLast;
      end
      if (ovfNow) ovfFlag <= 1'b1;
      if (regWrEn) begin
        case (regAddr)
          2'd0:    promisc <= regWrData[0];
          2'd1:    staLo   <= regWrData;
          2'd2:    staHi   <= regWrData[15:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {ovfFlag, 30'd0, promisc};
      2'd1:    regRdData = staLo;
      2'd2:    regRdData = {16'd0, staHi};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_filt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] inData,
  input  logic [7:0]  inKeep,
  input  logic        inLast,
  input  logic        inGood,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        outValid,
  output logic [63:0] outData,
  output logic [7:0]  outKeep,
  output logic        outLast
);
  fifoStrobe_t fifoStr;
  logic        fifoFull;
  logic        ovfFlag;

  eth_filt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .hdr(inData[47:0]),
    .inLast(inLast), .inGood(inGood), .full(fifoFull),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .str(fifoStr), .ovfFlag(ovfFlag)
  );

  eth_filt_fifo #(.DW(64), .KW(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .str(fifoStr), .inData(inData), .inKeep(inKeep),
    .inLast(inLast), .full(fifoFull), .outValid(outValid), .outData(outData),
    .outKeep(outKeep), .outLast(outLast)
  );
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk
  import eth_filt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inLast,
  input logic        inGood,
  input logic        full,
  input fifoStrobe_t str,
  input logic        ovfFlag
);
  // R7: the controller never asks for a store into a full FIFO
  p_no_write_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |-> !full);
  // R3: a frame is never both kept and discarded
  p_commit_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(str.commit && str.rewind));
  // R4: commits happen only on a last beat with good status
  p_commit_good_r4: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |-> (inValid && inLast && inGood));
  // R8: the overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  // R7: the flag only rises after a beat met a full FIFO
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(inValid && full));
endmodule

bind eth_rx_filter eth_rx_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inGood(inGood),
  .full(fifoFull), .str(fifoStr), .ovfFlag(ovfFlag)
);

// File: tb/eth_rx_filter_bench.sv
module eth_rx_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inKeep = '0;
  logic        inLast = 1'b0;
  logic        inGood = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        outValid;
  logic [63:0] outData;
  logic [7:0]  outKeep;
  logic        outLast;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cycles = 0;

  logic [47:0] staModel = 48'hEEFF_AABB_CCDD;
  bit          promModel = 0;
  logic [72:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  eth_rx_filter u_eth_rx_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inKeep(inKeep),
    .inLast(inLast), .inGood(inGood), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .outValid(outValid),
    .outData(outData), .outKeep(outKeep), .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input logic [72:0] act, input logic [72:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare committed beats
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      if (expQ.size() == 0) begin
        check(0, "R3/R4/R7 unexpected beat", {outLast, outKeep, outData}, '0);
      end else begin
        logic [72:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({outLast, outKeep, outData} === e, t, {outLast, outKeep, outData}, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData === exp, tag, {41'd0, regRdData}, {41'd0, exp});
  endtask

  // drives one frame; expectation computed from the requirements
  task automatic sendFrame(input logic [47:0] dest, input int nBeats, input bit good,
                           input bit forceDrop, input bit gap, input string tag);
    bit pass;
    pass = good && !forceDrop && (promModel || dest == staModel || dest == 48'hFFFF_FFFF_FFFF);
    for (int b = 0; b < nBeats; b++) begin
      logic [63:0] d;
      logic [7:0]  k;
      bit          l;
      d = {$urandom, $urandom};
      if (b == 0) for (int i = 0; i < 6; i++) d[8*i +: 8] = dest[8*(5-i) +: 8];
      l = (b == nBeats - 1);
      k = l ? (8'hFF >> (nBeats % 8)) : 8'hFF;
      if (pass) begin
        expQ.push_back({l, k, d});
        tagQ.push_back(tag);
      end
      @(negedge clk);
      inValid = 1'b1; inData = d; inKeep = k; inLast = l; inGood = l ? good : 1'b0;
    end
    if (gap) begin
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, tag, 73'(expQ.size()), 73'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regCheck(2'd0, 32'h0000_0000, "R1 ctrl reset");
    regCheck(2'd1, 32'hAABB_CCDD, "R1 addr low reset");
    regCheck(2'd2, 32'h0000_EEFF, "R1 addr high reset");
    check(outValid === 1'b0, "R1 outValid reset", {72'd0, outValid}, 73'd0);

    // R2 + R9: single-beat matching frame, output the cycle after its last edge
    sendFrame(48'hEEFF_AABB_CCDD, 1, 1, 0, 0, "R2 single beat match");
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, "R9 first beat timing", {72'd0, outValid}, 73'd1);
    drain("R2 drained");

    sendFrame(48'hEEFF_AABB_CCDD, 4, 1, 0, 1, "R2 multi beat match");
    // byte-reversed station address must not match
    sendFrame(48'hDDCC_BBAA_FFEE, 3, 1, 0, 1, "R3 reversed address");
    sendFrame(48'h0102_0304_0506, 2, 1, 0, 1, "R3 mismatch");
    sendFrame(48'hEEFF_AABB_CCDD, 3, 0, 0, 1, "R4 bad status");
    sendFrame(48'hFFFF_FFFF_FFFF, 2, 1, 0, 1, "R5 broadcast");
    drain("R2 R3 R4 R5 drained");

    // R2 new station address
    regWrite(2'd1, 32'h1234_5678);
    regWrite(2'd2, 32'hFFFF_9ABC);
    staModel = 48'h9ABC_1234_5678;
    regCheck(2'd2, 32'h0000_9ABC, "R2 addr high readback");
    sendFrame(48'h9ABC_1234_5678, 5, 1, 0, 1, "R2 new station");
    sendFrame(48'hEEFF_AABB_CCDD, 2, 1, 0, 1, "R3 old station");
    drain("R2 new station drained");

    // R6 promiscuous
    regWrite(2'd0, 32'h0000_0001);
    promModel = 1;
    regCheck(2'd0, 32'h0000_0001, "R6 promisc readback");
    sendFrame(48'h0A0B_0C0D_0E0F, 3, 1, 0, 1, "R6 promisc any");
    sendFrame(48'h0A0B_0C0D_0E0F, 2, 0, 0, 1, "R4 promisc bad");
    regWrite(2'd0, 32'h0000_0000);
    promModel = 0;
    drain("R6 drained");

    // R9 back-to-back: drop then pass, in order
    sendFrame(48'h1111_2222_3333, 3, 1, 0, 0, "R3 b2b drop");
    sendFrame(48'h9ABC_1234_5678, 3, 1, 0, 0, "R9 b2b pass a");
    sendFrame(48'hFFFF_FFFF_FFFF, 1, 1, 0, 0, "R9 b2b pass b");
    sendFrame(48'h9ABC_1234_5678, 2, 0, 0, 1, "R4 b2b bad");
    drain("R9 b2b drained");

    // R7 overflow: frame longer than the FIFO
    sendFrame(48'h9ABC_1234_5678, 20, 1, 1, 1, "R7 overflow frame");
    drain("R7 overflow drained");
    regCheck(2'd0, 32'h8000_0000, "R7 overflow flag");
    // R8 sticky, normal filtering continues, write leaves bit 31
    sendFrame(48'h9ABC_1234_5678, 4, 1, 0, 1, "R8 after overflow");
    sendFrame(48'h4444_5555_6666, 2, 1, 0, 1, "R8 filter after overflow");
    regWrite(2'd0, 32'h0000_0000);
    drain("R8 drained");
    regCheck(2'd0, 32'h8000_0000, "R8 flag sticky");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule